// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits behind the receive side of an Ethernet PHY and takes its byte stream. The PHY marks each byte with a valid strobe and flags the final byte of each packet. The block looks for the start-of-frame delimiter and ignores any run of preamble in front of it, whatever its length. It then passes the bytes that follow onward, with start and end markers. As the bytes arrive, it classifies the destination address and runs a CRC-32 check. It also measures the frame length against the minimum and maximum payload sizes.

A status byte comes out on the same cycle as the end marker. It holds the address class, the error flags and an accept bit, and the accept bit is cleared when the frame is to be dropped. Four static controls set the policy: whether short frames are allowed, whether long frames are allowed, whether frames with a bad CRC are allowed, and whether the four CRC bytes are removed from the output. The output runs four bytes behind the input, so the CRC bytes can be held back without knowing the frame length in advance. Controls are expected to change only between frames, and successive packets must be at least five cycles apart.

Top module: `rx_frame_filter`

## Requirements
- R1: Bytes before the first 0xD5 byte of a packet are discarded, however many there are (none is allowed). The frame is every byte after that 0xD5, up to and including the byte flagged last. `out_sof` marks the first output byte.
- R2: On the end cycle, status bit 0 (unicast) is the inverse of bit 0 of the first frame byte, and status bit 1 (group) equals that bit.
- R3: Status bit 2 (broadcast) is set exactly when the first six frame bytes are all 0xFF. Bits 1 and 3 are then also set.
- R4: Status bit 3 (locally administered) equals bit 1 of the first frame byte.
- R5: Status bit 4 (CRC error) is set when the frame check fails. The check runs a reflected CRC-32 over the frame with initial value all ones. The final field is the complemented CRC, sent low byte first. The check passes when the register ends at 0xDEBB20E3.
- R6: Status bit 5 (short) is set when the frame is shorter than 64 bytes, i.e. its payload is under 46 bytes. Such a frame is accepted only with `cfg_short_ok` high.
- R7: Status bit 6 (long) is set when the frame is longer than 1518 bytes, i.e. its payload exceeds 1500 bytes. Such a frame is accepted only with `cfg_long_ok` high.
- R8: A frame with a CRC error is accepted only with `cfg_badcrc_ok` high.
- R9: Status bit 7 (accept) is the conjunction of the three conditions in R6 to R8, and a frame with bit 7 clear is to be dropped. `out_status` is zero on every cycle without `out_eof`, including after reset.
- R10: With `cfg_strip_crc` high, the output carries the frame bytes except the last four, in order. `out_eof` is on the last of these bytes, one cycle after the final input byte. With it low, all frame bytes are passed and `out_eof` is on the last one.
- R11: A frame of four bytes or fewer produces no output bytes and no end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a packet |
| cfg_short_ok | input | 1 | Accept frames below the minimum size |
| cfg_long_ok | input | 1 | Accept frames above the maximum size |
| cfg_badcrc_ok | input | 1 | Accept frames that fail the CRC check |
| cfg_strip_crc | input | 1 | Remove the four CRC bytes from the output |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame; status valid |
| out_status | output | 8 | Frame status, see R2 to R9 |

## Verification
Some properties are checked on every cycle: the address class bits agree with one another, broadcast implies group and local, and every error flag leads to a cleared accept bit unless its enable is set. The checks also confirm that entry into a frame follows a delimiter byte, and that in strip mode the end strobe comes one cycle after the final input byte. Only the bench scenarios can show that the bytes themselves come out complete and in order, and that the CRC residue and length thresholds fall at the right byte counts. The bench sweeps every control setting across frame lengths on both sides of each limit, with good and corrupted CRCs, several address kinds and preamble lengths. It also covers frames of one to four bytes.

// File: rtl/rxf_pkg.sv
// Shared constants, status layout and the CRC-32 byte step for the receive filter.
package rxf_pkg;

    localparam logic [7:0]  SFD_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    // Status byte, bit 7 down to bit 0.
    typedef struct packed {
        logic accept;
        logic too_long;
        logic too_short;
        logic crc_bad;
        logic local_adm;
        logic bcast;
        logic mcast;
        logic ucast;
    } rx_status_t;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? CRC_POLY_R : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_sfd_hunt.sv
// Delimiter hunter: discards everything before the first SFD byte of a packet,
// then forwards the bytes that follow until the byte flagged last.
// Assumes in_last is only meaningful together with in_valid.
module rxf_sfd_hunt
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       frm_start,
    output logic       frm_valid,
    output logic [7:0] frm_data,
    output logic       frm_last
);

    logic in_frame_q;

    // Decode delimiter and forward frame bytes.
    always_comb begin
        frm_start = in_valid && !in_frame_q && (in_data == SFD_BYTE) && !in_last;
        frm_valid = in_valid && in_frame_q;
        frm_data  = in_data;
        frm_last  = in_last;
    end

    // Track whether the stream is inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                     in_frame_q <= 1'b0;
        else if (frm_start)             in_frame_q <= 1'b1;
        else if (frm_valid && in_last)  in_frame_q <= 1'b0;
    end

    // R1
    sfd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_q) |-> ($past(in_valid) && $past(in_data) == SFD_BYTE));

endmodule

// File: rtl/rxf_crc32.sv
// CRC accumulator: restarts on frame start and folds in each frame byte.
// crc_next is the value including the current byte, used on the last one.
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        valid,
    input  logic [7:0]  data,
    output logic [31:0] crc_next
);

    logic [31:0] crc_q;

    // Combinational step over the current byte.
    always_comb crc_next = crc32_step(crc_q, data);

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_INIT;
        else if (start)  crc_q <= CRC_INIT;
        else if (valid)  crc_q <= crc_next;
    end

endmodule

// File: rtl/rxf_hold_line.sv
// Output delay line of DEPTH bytes. Holding DEPTH bytes lets the trailing
// DEPTH bytes be dropped (strip) or drained after the last byte (pass).
// Assumes no new frame byte arrives while draining.
module rxf_hold_line #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_v,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       strip,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    hold_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] drain_q;
    logic          first_q;
    logic          full;

    always_comb full = (cnt_q == CW'(DEPTH));

    // Fill, shift, emit and drain the held bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hold_q[i] <= '0;
            cnt_q     <= '0;
            drain_q   <= '0;
            first_q   <= 1'b1;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            if (drain_q != '0) begin
                out_valid <= 1'b1;
                out_data  <= hold_q[0];
                out_eof   <= (drain_q == CW'(1));
                for (int i = 0; i < DEPTH - 1; i++) hold_q[i] <= hold_q[i+1];
                hold_q[DEPTH-1] <= '0;
                drain_q <= drain_q - CW'(1);
            end else if (in_v) begin
                if (full) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q[0];
                    out_sof   <= first_q;
                    first_q   <= 1'b0;
                    for (int i = 0; i < DEPTH - 1; i++) hold_q[i] <= hold_q[i+1];
                    hold_q[DEPTH-1] <= in_data;
                end else begin
                    hold_q[cnt_q[AW-1:0]] <= in_data;
                    cnt_q <= cnt_q + CW'(1);
                end
                if (in_last) begin
                    cnt_q   <= '0;
                    first_q <= 1'b1;
                    if (full) begin
                        if (strip) out_eof <= 1'b1;
                        else       drain_q <= CW'(DEPTH);
                    end
                end
            end
        end
    end

    // R10
    no_byte_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_q != '0) |-> !in_v);

    // R10
    strip_eof_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && strip && $past(strip)) |-> $past(in_v && in_last));

    // R11
    eof_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

endmodule

// File: rtl/rx_frame_filter.sv
// Receive frame filter: strips preamble and delimiter, classifies the
// destination address, checks CRC and length, and emits bytes with a
// status byte on the end strobe. Controls must be steady during a frame.
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int MIN_PAYLOAD = 46,
    parameter int MAX_PAYLOAD = 1500,
    parameter int HDR_BYTES   = 14,
    parameter int FCS_BYTES   = 4,
    parameter int ADDR_BYTES  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       cfg_short_ok,
    input  logic       cfg_long_ok,
    input  logic       cfg_badcrc_ok,
    input  logic       cfg_strip_crc,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic [7:0] out_status
);

    localparam int MIN_FRAME = HDR_BYTES + MIN_PAYLOAD + FCS_BYTES;
    localparam int MAX_FRAME = HDR_BYTES + MAX_PAYLOAD + FCS_BYTES;
    localparam int LEN_W     = $clog2(MAX_FRAME + 2);

    logic             frm_start, frm_valid, frm_last;
    logic [7:0]       frm_data;
    logic [31:0]      crc_next;
    logic [LEN_W-1:0] cnt_q, len_n;
    logic             grp_q, loc_q, bc_q;
    logic             grp_n, loc_n, bc_n;
    rx_status_t       st_n, stat_q, st_out;

    rxf_sfd_hunt u_hunt (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .frm_start(frm_start), .frm_valid(frm_valid),
        .frm_data(frm_data), .frm_last(frm_last)
    );

    rxf_crc32 u_crc (
        .clk(clk), .rst_n(rst_n),
        .start(frm_start), .valid(frm_valid), .data(frm_data),
        .crc_next(crc_next)
    );

    rxf_hold_line #(.DEPTH(FCS_BYTES)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .in_v(frm_valid), .in_data(frm_data), .in_last(frm_last),
        .strip(cfg_strip_crc),
        .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    // Next-state address class, length and status including this byte.
    always_comb begin
        len_n = (cnt_q == {LEN_W{1'b1}}) ? cnt_q : cnt_q + LEN_W'(1);
        if (cnt_q == '0) begin
            grp_n = frm_data[0];
            loc_n = frm_data[1];
            bc_n  = (frm_data == 8'hFF);
        end else begin
            grp_n = grp_q;
            loc_n = loc_q;
            bc_n  = (cnt_q < LEN_W'(ADDR_BYTES)) ? (bc_q && frm_data == 8'hFF) : bc_q;
        end
        st_n.ucast     = !grp_n;
        st_n.mcast     = grp_n;
        st_n.bcast     = bc_n;
        st_n.local_adm = loc_n;
        st_n.crc_bad   = (crc_next != CRC_RESIDUE);
        st_n.too_short = (len_n < LEN_W'(MIN_FRAME));
        st_n.too_long  = (len_n > LEN_W'(MAX_FRAME));
        st_n.accept    = (!st_n.crc_bad   || cfg_badcrc_ok) &&
                         (!st_n.too_short || cfg_short_ok)  &&
                         (!st_n.too_long  || cfg_long_ok);
    end

    // Per-frame byte count, address class and captured status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            grp_q  <= 1'b0;
            loc_q  <= 1'b0;
            bc_q   <= 1'b0;
            stat_q <= '0;
        end else if (frm_start) begin
            cnt_q <= '0;
        end else if (frm_valid) begin
            cnt_q <= len_n;
            grp_q <= grp_n;
            loc_q <= loc_n;
            bc_q  <= bc_n;
            if (frm_last) stat_q <= st_n;
        end
    end

    // Status is shown only with the end strobe.
    always_comb begin
        st_out     = out_eof ? stat_q : '0;
        out_status = st_out;
    end

    // R2
    cast_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (st_out.ucast != st_out.mcast));

    // R3
    bcast_implies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && st_out.bcast) |-> (st_out.mcast && st_out.local_adm));

    // R6
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && st_out.too_short && !cfg_short_ok) |-> !st_out.accept);

    // R7
    long_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && st_out.too_long && !cfg_long_ok) |-> !st_out.accept);

    // R8
    badcrc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof && st_out.crc_bad && !cfg_badcrc_ok) |-> !st_out.accept);

endmodule

// File: tb/rx_frame_filter_bench.sv
module rx_frame_filter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       cfg_short_ok = 1'b0, cfg_long_ok = 1'b0, cfg_badcrc_ok = 1'b0, cfg_strip_crc = 1'b0;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_data, out_status;

    always #5 clk = ~clk;

    rx_frame_filter u_rx_frame_filter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .cfg_short_ok(cfg_short_ok), .cfg_long_ok(cfg_long_ok),
        .cfg_badcrc_ok(cfg_badcrc_ok), .cfg_strip_crc(cfg_strip_crc),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_status(out_status)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] fr  [0:2047];
    logic [7:0] cap [0:2047];
    int ncap = 0, nsof = 0, neof = 0, eof_idx = -1, leak = 0;
    logic sof_first = 1'b0;
    logic [7:0] cap_stat = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ d[i]) ? 32'hEDB88320 : 32'h0);
        return r;
    endfunction

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            cap[ncap] = out_data;
            if (ncap == 0) sof_first = out_sof;
            if (out_sof) nsof++;
            if (out_eof) begin neof++; cap_stat = out_status; eof_idx = ncap; end
            ncap++;
        end
        if (rst_n && !out_eof && out_status != 8'h00) leak++;
    end

    task automatic drive(input logic v, input logic [7:0] d, input logic l);
        @(negedge clk);
        in_valid = v; in_data = d; in_last = l;
    endtask

    task automatic send(input int pre, input int len);
        ncap = 0; nsof = 0; neof = 0; eof_idx = -1; leak = 0;
        for (int p = 0; p < pre; p++) drive(1'b1, 8'h55, 1'b0);
        drive(1'b1, 8'hD5, 1'b0);
        for (int k = 0; k < len; k++) begin
            if (k % 17 == 16) drive(1'b0, 8'h00, 1'b0);
            drive(1'b1, fr[k], k == len - 1);
        end
        for (int g = 0; g < 10; g++) drive(1'b0, 8'h00, 1'b0);
    endtask

    // Build a frame of len bytes with address kind t; good or corrupted CRC.
    task automatic build(input int len, input int t, input int seed, input bit good);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < len; k++) fr[k] = 8'((k * 37 + len * 3 + seed * 11) ^ 8'h5A);
        case (t)
            0: fr[0] = 8'h10;
            1: fr[0] = 8'h12;
            2: fr[0] = 8'h01;
            3: for (int k = 0; k < 6 && k < len; k++) fr[k] = 8'hFF;
            4: fr[0] = 8'h33;
            default: begin
                for (int k = 0; k < 6 && k < len; k++) fr[k] = 8'hFF;
                if (len > 5) fr[5] = 8'hFE;
            end
        endcase
        if (len >= 5) begin
            for (int k = 0; k < len - 4; k++) c = crc_b(c, fr[k]);
            c = ~c;
            for (int k = 0; k < 4; k++) fr[len - 4 + k] = c[8*k +: 8];
            if (!good) fr[len - 1] = fr[len - 1] ^ 8'h01;
        end
    endtask

    task automatic verify(input int len, input int cfg, input bit good);
        int n, bad;
        bit grp, loc, bc, sh, lg, acc;
        logic [7:0] e;
        n = cfg[3] ? len - 4 : len;
        chk(ncap == n, "R10 byte count", ncap, n);
        bad = -1;
        for (int k = 0; k < n && k < ncap; k++) if (bad < 0 && cap[k] !== fr[k]) bad = k;
        chk(bad < 0, "R10 byte order", bad, -1);
        chk(sof_first && nsof == 1, "R1 sof once on first", nsof, 1);
        chk(neof == 1 && eof_idx == n - 1, "R10 eof position", eof_idx, n - 1);
        chk(leak == 0, "R9 status only on eof", leak, 0);
        grp = fr[0][0]; loc = fr[0][1];
        bc = 1'b1;
        for (int k = 0; k < 6 && k < len; k++) if (fr[k] != 8'hFF) bc = 1'b0;
        sh = len < 64; lg = len > 1518;
        acc = (good || cfg[2]) && (!sh || cfg[0]) && (!lg || cfg[1]);
        e = {acc, lg, sh, !good, loc, bc, grp, !grp};
        chk(cap_stat[1:0] == e[1:0], "R2 ucast/mcast", cap_stat[1:0], e[1:0]);
        chk(cap_stat[2] == e[2], "R3 bcast", cap_stat[2], e[2]);
        chk(cap_stat[3] == e[3], "R4 local", cap_stat[3], e[3]);
        chk(cap_stat[4] == e[4], "R5 crc error", cap_stat[4], e[4]);
        chk(cap_stat[5] == e[5], "R6 short", cap_stat[5], e[5]);
        chk(cap_stat[6] == e[6], "R7 long", cap_stat[6], e[6]);
        chk(cap_stat[7] == e[7], "R8 R9 accept", cap_stat[7], e[7]);
    endtask

    int lens [8] = '{5, 6, 20, 63, 64, 65, 1518, 1519};
    int pres [4] = '{0, 1, 7, 12};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_status == 8'h00, "R9 reset state", out_status, 0);
        for (int cfg = 0; cfg < 16; cfg++) begin
            cfg_short_ok  = cfg[0];
            cfg_long_ok   = cfg[1];
            cfg_badcrc_ok = cfg[2];
            cfg_strip_crc = cfg[3];
            for (int li = 0; li < 8; li++) begin
                for (int g = 0; g < 2; g++) begin
                    build(lens[li], (cfg + li + g) % 6, cfg, g == 1);
                    send(pres[(li + g) % 4], lens[li]);
                    verify(lens[li], cfg, g == 1);
                end
            end
        end
        // R11: frames of one to four bytes give no output in either mode.
        for (int s = 0; s < 2; s++) begin
            cfg_strip_crc = s[0];
            for (int len = 1; len <= 4; len++) begin
                build(len, 0, len, 1'b1);
                send(3, len);
                chk(ncap == 0 && neof == 0, "R11 runt silent", ncap, 0);
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule